// File: doc/BRIEF.md
# Register Status Rename Table

This block keeps, for every architectural register of a dynamically scheduled core, a small status field. The field holds the tag of the in-flight station that will produce the register's next value, or zero when the register file already holds the current value. Beside the status fields sits the register file itself, held in two block-RAM-friendly banks so that both source operands can be read in the same cycle.

When an instruction issues, the table reads both source registers. For each one it returns either a ready value with tag zero, or the tag of the producer to wait for. It then records the issuing station's tag as the new owner of the destination register. A later writer of the same register simply replaces the older tag, so only the newest rename survives. Results come back over one shared broadcast of tag and value. A register takes the value and drops its status only when its recorded tag equals the broadcast tag, so a stale producer can never overwrite a newer rename. Lookup results come out on registered outputs one cycle after the issue is presented.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register's status is zero, so a lookup of any register returns tag 0.
- R2: A lookup of a register whose status is zero returns tag 0 and the register's stored value on the outputs one cycle after `iss_valid` is sampled high.
- R3: A lookup of a register whose status is nonzero returns that tag, with the value field forced to 0.
- R4: An issue with `iss_valid` and `iss_dst_en` high stores `iss_tag` as the status of `iss_dst`. A second issue to the same register replaces the earlier tag.
- R5: A broadcast with a nonzero tag equal to a register's status writes `bc_value` into that register and clears its status to zero.
- R6: A broadcast whose tag matches no register's status changes neither the status nor the value of any register.
- R7: When a register is renamed in the same cycle that a broadcast clears it, the register afterwards carries the new tag.
- R8: A source lookup whose register status equals the tag being broadcast in the same cycle returns tag 0 and the broadcast value.
- R9: The sources of an issue see the state from before that issue's own destination rename, so a source equal to the destination returns the older state.
- R10: A broadcast carrying tag 0 is ignored, and no register with zero status is written by it.
- R11: `res_valid` is high exactly in the cycle after an issue is sampled. In other cycles both tag and value outputs read 0.
- R12: With `iss_valid` low, `iss_dst_en`, `iss_dst` and `iss_tag` have no effect on any register's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_src_a | input | IDX_W | First source register index |
| iss_src_b | input | IDX_W | Second source register index |
| iss_dst_en | input | 1 | The issuing instruction writes a register |
| iss_dst | input | IDX_W | Destination register index |
| iss_tag | input | TAG_W | Tag of the issuing station (nonzero) |
| bc_valid | input | 1 | A result is broadcast this cycle |
| bc_tag | input | TAG_W | Tag of the station producing the result |
| bc_value | input | DATA_W | Broadcast result value |
| res_valid | output | 1 | Lookup results are valid |
| opa_tag | output | TAG_W | First source producer tag, 0 when ready |
| opa_value | output | DATA_W | First source value, 0 when waiting |
| opb_tag | output | TAG_W | Second source producer tag, 0 when ready |
| opb_value | output | DATA_W | Second source value, 0 when waiting |

## Verification
Three functions can land in one cycle: the issue-time lookup, the destination rename, and the broadcast clear. The bench provokes each pair on purpose. It renames a register while the broadcast of its old tag arrives, and judges that the newer tag stays in place. It looks up a pending register while its producer broadcasts, and judges that the broadcast value is forwarded with tag 0. It issues an instruction that reads and writes the same register, and judges that the old value is returned while the new tag takes hold afterwards.

// File: rtl/rst_pkg.sv
package rst_pkg;

  localparam int DEF_NREGS  = 16;
  localparam int DEF_TAG_W  = 4;
  localparam int DEF_DATA_W = 32;

  // Where a registered lookup result takes its value from
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,  // no lookup in the previous cycle
    SRC_FILE  = 2'd1,  // register file bank output
    SRC_BCAST = 2'd2,  // forwarded broadcast value
    SRC_WAIT  = 2'd3   // producer still in flight
  } val_src_e;

endpackage

// File: rtl/rst_status_table.sv
module rst_status_table #(
  parameter int NREGS = 16,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ren_en,
  input  logic [IDX_W-1:0]             ren_idx,
  input  logic [TAG_W-1:0]             ren_tag,
  input  logic                         bc_valid,
  input  logic [TAG_W-1:0]             bc_tag,
  output logic [NREGS-1:0][TAG_W-1:0]  stat_o,
  output logic                         wr_hit,
  output logic [IDX_W-1:0]             wr_idx
);

  logic [NREGS-1:0][TAG_W-1:0] stat_q;
  logic [NREGS-1:0]            match;
  logic                        bc_live;

  assign bc_live = bc_valid && (bc_tag != '0);

  generate
    for (genvar g = 0; g < NREGS; g++) begin : g_entry
      assign match[g] = bc_live && (stat_q[g] == bc_tag);

      always_ff @(posedge clk) begin
        if (rst) begin
          stat_q[g] <= '0;
        end else if (ren_en && (ren_idx == IDX_W'(g))) begin
          stat_q[g] <= ren_tag;       // newest writer wins
        end else if (match[g]) begin
          stat_q[g] <= '0;            // producer has delivered
        end
      end
    end
  endgenerate

  // Tags are unique among in-flight stations, so at most one entry matches.
  always_comb begin
    wr_idx = '0;
    for (int i = NREGS - 1; i >= 0; i--) begin
      if (match[i]) wr_idx = IDX_W'(i);
    end
  end

  assign wr_hit = |match;
  assign stat_o = stat_q;

endmodule

// File: rtl/rst_value_bank.sv
module rst_value_bank #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Single write, single synchronous read, read-before-write.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/rst_lookup_port.sv
module rst_lookup_port
  import rst_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [TAG_W-1:0]  src_stat,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  input  logic [DATA_W-1:0] bank_data,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] value_o
);

  val_src_e          src_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] fwd_q;
  logic              hit;

  assign hit = bc_valid && (bc_tag != '0) && (src_stat == bc_tag);

  always_ff @(posedge clk) begin
    if (rst || !req) begin
      src_q <= SRC_IDLE;
      tag_q <= '0;
    end else if (hit) begin
      src_q <= SRC_BCAST;
      tag_q <= '0;
    end else if (src_stat != '0) begin
      src_q <= SRC_WAIT;
      tag_q <= src_stat;
    end else begin
      src_q <= SRC_FILE;
      tag_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (req && hit) fwd_q <= bc_value;
  end

  always_comb begin
    unique case (src_q)
      SRC_FILE:  value_o = bank_data;
      SRC_BCAST: value_o = fwd_q;
      default:   value_o = '0;
    endcase
  end

  assign tag_o = tag_q;

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rst_pkg::*;
#(
  parameter int NREGS  = DEF_NREGS,
  parameter int TAG_W  = DEF_TAG_W,
  parameter int DATA_W = DEF_DATA_W,
  localparam int IDX_W = $clog2(NREGS),
  localparam int NPORT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_src_a,
  input  logic [IDX_W-1:0]  iss_src_b,
  input  logic              iss_dst_en,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_value,
  output logic              res_valid,
  output logic [TAG_W-1:0]  opa_tag,
  output logic [DATA_W-1:0] opa_value,
  output logic [TAG_W-1:0]  opb_tag,
  output logic [DATA_W-1:0] opb_value
);

  logic [NREGS-1:0][TAG_W-1:0] stat_q;
  logic                        wr_hit;
  logic [IDX_W-1:0]            wr_idx;
  logic [NPORT-1:0][IDX_W-1:0] src_idx;
  logic [NPORT-1:0][TAG_W-1:0] port_tag;
  logic [DATA_W-1:0]           port_val  [NPORT];
  logic [DATA_W-1:0]           bank_rd   [NPORT];
  logic                        valid_q;

  assign src_idx[0] = iss_src_a;
  assign src_idx[1] = iss_src_b;

  rst_status_table #(.NREGS(NREGS), .TAG_W(TAG_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .ren_en   (iss_valid && iss_dst_en),
    .ren_idx  (iss_dst),
    .ren_tag  (iss_tag),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .stat_o   (stat_q),
    .wr_hit   (wr_hit),
    .wr_idx   (wr_idx)
  );

  // One bank copy per read port, all written by the broadcast.
  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      rst_value_bank #(.DEPTH(NREGS), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .we    (wr_hit),
        .waddr (wr_idx),
        .wdata (bc_value),
        .raddr (src_idx[p]),
        .rdata (bank_rd[p])
      );

      rst_lookup_port #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_look (
        .clk       (clk),
        .rst       (rst),
        .req       (iss_valid),
        .src_stat  (stat_q[src_idx[p]]),
        .bc_valid  (bc_valid),
        .bc_tag    (bc_tag),
        .bc_value  (bc_value),
        .bank_data (bank_rd[p]),
        .tag_o     (port_tag[p]),
        .value_o   (port_val[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= iss_valid;
  end

  assign res_valid = valid_q;
  assign opa_tag   = port_tag[0];
  assign opa_value = port_val[0];
  assign opb_tag   = port_tag[1];
  assign opb_value = port_val[1];

endmodule

// File: rtl/rst_table_checker.sv
module rst_table_checker #(
  parameter int NREGS  = 16,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        iss_valid,
  input logic [IDX_W-1:0]            iss_src_a,
  input logic                        iss_dst_en,
  input logic [IDX_W-1:0]            iss_dst,
  input logic [TAG_W-1:0]            iss_tag,
  input logic                        bc_valid,
  input logic [TAG_W-1:0]            bc_tag,
  input logic [DATA_W-1:0]           bc_value,
  input logic                        res_valid,
  input logic [TAG_W-1:0]            opa_tag,
  input logic [DATA_W-1:0]           opa_value,
  input logic [NREGS-1:0][TAG_W-1:0] stat
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (stat == '0));  // R1

  AST_WAIT_VALUE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (res_valid && opa_tag != '0) |-> (opa_value == '0));  // R3

  AST_RENAME_TAKES: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_dst_en) |=> (stat[$past(iss_dst)] == $past(iss_tag)));  // R4

  AST_FORWARD_HIT: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && bc_valid && bc_tag != '0 && stat[iss_src_a] == bc_tag)
      |=> (opa_tag == '0 && opa_value == $past(bc_value)));  // R8

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> res_valid);  // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> (!res_valid && opa_tag == '0 && opa_value == '0));  // R11

  generate
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
      AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (bc_valid && bc_tag != '0 && stat[g] == bc_tag &&
         !(iss_valid && iss_dst_en && iss_dst == IDX_W'(g)))
          |=> (stat[g] == '0));  // R5

      AST_STALE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!(bc_valid && bc_tag != '0 && stat[g] == bc_tag) &&
         !(iss_valid && iss_dst_en && iss_dst == IDX_W'(g)))
          |=> $stable(stat[g]));  // R6
    end
  endgenerate

endmodule

bind rename_status_table rst_table_checker #(
  .NREGS(NREGS), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .iss_valid  (iss_valid),
  .iss_src_a  (iss_src_a),
  .iss_dst_en (iss_dst_en),
  .iss_dst    (iss_dst),
  .iss_tag    (iss_tag),
  .bc_valid   (bc_valid),
  .bc_tag     (bc_tag),
  .bc_value   (bc_value),
  .res_valid  (res_valid),
  .opa_tag    (opa_tag),
  .opa_value  (opa_value),
  .stat       (stat_q)
);

// File: tb/test_rename_status_table.sv
module test_rename_status_table;

  localparam int CLK_P  = 10;
  localparam int NREGS  = 16;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(NREGS);

  logic              clk = 1'b0;
  logic              rst;
  logic              iss_valid, iss_dst_en, bc_valid;
  logic [IDX_W-1:0]  iss_src_a, iss_src_b, iss_dst;
  logic [TAG_W-1:0]  iss_tag, bc_tag;
  logic [DATA_W-1:0] bc_value;
  logic              res_valid;
  logic [TAG_W-1:0]  opa_tag, opb_tag;
  logic [DATA_W-1:0] opa_value, opb_value;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_P/2) clk = ~clk;

  rename_status_table #(.NREGS(NREGS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_rename_status_table (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .res_valid(res_valid), .opa_tag(opa_tag), .opa_value(opa_value),
    .opb_tag(opb_tag), .opb_value(opb_value)
  );

  task automatic idle_inputs();
    iss_valid = 0; iss_dst_en = 0; bc_valid = 0;
    iss_src_a = '0; iss_src_b = '0; iss_dst = '0; iss_tag = '0;
    bc_tag = '0; bc_value = '0;
  endtask

  // One cycle of stimulus; outputs of that cycle are visible on return.
  task automatic step(input bit iv, input int sa, input int sb,
                      input bit dv, input int d, input int t,
                      input bit bv, input int bt, input logic [DATA_W-1:0] bd);
    @(negedge clk);
    iss_valid = iv; iss_src_a = IDX_W'(sa); iss_src_b = IDX_W'(sb);
    iss_dst_en = dv; iss_dst = IDX_W'(d); iss_tag = TAG_W'(t);
    bc_valid = bv; bc_tag = TAG_W'(bt); bc_value = bd;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input int ra, input int rb);
    step(1, ra, rb, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic rename(input int r, input int t);
    step(1, 0, 0, 1, r, t, 0, 0, '0);
  endtask

  task automatic bcast(input int t, input logic [DATA_W-1:0] v);
    step(0, 0, 0, 0, 0, 0, 1, t, v);
  endtask

  task automatic load(input int r, input int t, input logic [DATA_W-1:0] v);
    rename(r, t);
    bcast(t, v);
  endtask

  task automatic t_reset();
    step(0, 0, 0, 0, 0, 0, 0, 0, '0);
    chk(res_valid == 0, "R11 idle valid", res_valid, 0);
    chk(opa_tag == 0 && opa_value == 0, "R11 idle outputs", opa_value, 0);
    look(0, 15);
    chk(res_valid == 1, "R11 valid after issue", res_valid, 1);
    chk(opa_tag == 0, "R1 reg0 tag", opa_tag, 0);
    chk(opb_tag == 0, "R1 reg15 tag", opb_tag, 0);
  endtask

  task automatic t_plain();
    load(3, 1, 32'h0000_00A5);
    look(3, 3);
    chk(opa_tag == 0 && opa_value == 32'hA5, "R2 ready value a", opa_value, 32'hA5);
    chk(opb_tag == 0 && opb_value == 32'hA5, "R5 written value b", opb_value, 32'hA5);
  endtask

  task automatic t_pending();
    rename(4, 5);
    look(4, 3);
    chk(opa_tag == 5, "R4 tag recorded", opa_tag, 5);
    chk(opa_value == 0, "R3 waiting value zero", opa_value, 0);
    bcast(5, 32'h44);
  endtask

  task automatic t_waw();
    rename(6, 1);
    rename(6, 2);
    look(6, 0);
    chk(opa_tag == 2, "R4 newer tag replaces", opa_tag, 2);
    bcast(1, 32'hDEAD);
    look(6, 0);
    chk(opa_tag == 2 && opa_value == 0, "R6 stale broadcast ignored", opa_tag, 2);
    bcast(2, 32'h66);
    look(6, 0);
    chk(opa_tag == 0 && opa_value == 32'h66, "R5 newest producer writes", opa_value, 32'h66);
  endtask

  task automatic t_stale();
    load(8, 3, 32'h88);
    bcast(9, 32'hBAD);
    look(8, 8);
    chk(opa_tag == 0 && opa_value == 32'h88, "R6 unmatched tag no write", opa_value, 32'h88);
  endtask

  task automatic t_race();
    rename(9, 4);
    step(1, 0, 0, 1, 9, 6, 1, 4, 32'h99);
    look(9, 0);
    chk(opa_tag == 6, "R7 new tag wins over clear", opa_tag, 6);
    bcast(6, 32'h96);
    look(9, 0);
    chk(opa_tag == 0 && opa_value == 32'h96, "R7 later producer lands", opa_value, 32'h96);
  endtask

  task automatic t_bypass();
    load(2, 3, 32'h22);
    rename(10, 7);
    step(1, 10, 2, 0, 0, 0, 1, 7, 32'h77);
    chk(opa_tag == 0 && opa_value == 32'h77, "R8 forwarded value", opa_value, 32'h77);
    chk(opb_tag == 0 && opb_value == 32'h22, "R8 other port from file", opb_value, 32'h22);
    look(10, 10);
    chk(opb_tag == 0 && opb_value == 32'h77, "R5 forwarded value stored", opb_value, 32'h77);
  endtask

  task automatic t_self();
    load(11, 3, 32'h33);
    step(1, 11, 11, 1, 11, 8, 0, 0, '0);
    chk(opa_tag == 0 && opa_value == 32'h33, "R9 source sees old state", opa_value, 32'h33);
    look(11, 0);
    chk(opa_tag == 8, "R9 rename after read", opa_tag, 8);
    bcast(8, 32'h38);
  endtask

  task automatic t_zero();
    load(12, 3, 32'h12);
    bcast(0, 32'hFF);
    look(12, 0);
    chk(opa_tag == 0 && opa_value == 32'h12, "R10 zero tag ignored", opa_value, 32'h12);
  endtask

  task automatic t_no_issue();
    step(0, 0, 0, 1, 13, 9, 0, 0, '0);
    chk(res_valid == 0, "R11 no issue no valid", res_valid, 0);
    look(13, 0);
    chk(opa_tag == 0, "R12 dst ignored without issue", opa_tag, 0);
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_plain();
    t_pending();
    t_waw();
    t_stale();
    t_race();
    t_bypass();
    t_self();
    t_zero();
    t_no_issue();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule